// File: doc/BRIEF.md
# Receive Character Queue with Per-Entry Error Status

This block buffers received characters between a serial receiver and the host. Every stored slot holds one data byte together with the break, framing and parity flags that the receiver captured with that byte. The error flags therefore leave the queue together with their byte. The host reads the byte at the head of the queue. A read strobe removes that byte, and the head status then moves on to the next stored character.

Next to the per-character status, the block keeps two summary indications. The first is an "error somewhere in the queue" flag. It is backed by a count of the stored entries that carry any error flag, so it only drops once the last such entry has been read out. The second is a sticky overrun flag. It is raised when a character arrives with no room for it, and only a line-status read clears it.

Top module: `rxq_errtrack`

## Requirements
- R1: The queue holds up to DEPTH entries (default 64). `fill_level` equals the number of stored entries. A write is accepted whenever the queue is not full.
- R2: Entries leave in arrival order. `rd_data` shows the oldest stored byte. A pulse on `rhr_rd` while the queue is not empty removes that byte.
- R3: `lsr_brk`, `lsr_fe` and `lsr_pe` show the flags of the head entry and follow it after each removal. While the queue is empty, these three outputs and `rd_data` are zero.
- R4: `lsr_err_any` is 1 exactly when at least one stored entry has any of its three flags set. It updates on the clock edge that stores or removes such an entry.
- R5: A write while the queue holds DEPTH entries and no removal occurs in the same cycle is an overrun. The new character is dropped and the stored contents and `fill_level` stay unchanged.
- R6: `lsr_oe` goes to 1 on the edge after an overrun. It stays 1 until a cycle with `lsr_rd` high and no new overrun. An overrun in the same cycle as `lsr_rd` leaves it at 1. Removing entries never clears it.
- R7: `data_rdy` is 1 exactly when `fill_level` is nonzero.
- R8: `rhr_rd` while the queue is empty has no effect on `fill_level`, `lsr_err_any` or `lsr_oe`.
- R9: A write and a removal in the same cycle leave `fill_level` unchanged and keep the error count exact. This also applies when the queue is full, and in that case no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Receiver delivers a character |
| wr_data | input | 8 | Received byte |
| wr_brk | input | 1 | Break flag of the received byte |
| wr_fe | input | 1 | Framing error flag of the received byte |
| wr_pe | input | 1 | Parity error flag of the received byte |
| rhr_rd | input | 1 | Host reads and removes the head byte |
| lsr_rd | input | 1 | Host reads line status (clears overrun) |
| rd_data | output | 8 | Head byte, zero when empty |
| lsr_err_any | output | 1 | Some stored entry carries an error |
| lsr_brk | output | 1 | Break flag of head entry |
| lsr_fe | output | 1 | Framing flag of head entry |
| lsr_pe | output | 1 | Parity flag of head entry |
| lsr_oe | output | 1 | Sticky overrun flag |
| data_rdy | output | 1 | Queue not empty |
| fill_level | output | 7 | Number of stored entries |

## Verification
The bench builds the block with its default parameters: DEPTH of 64 and a 7-bit fill level. Filling the whole queue takes only 64 writes, so the full boundary is within reach. That covers the dropped write, the full-queue write-with-removal case and pointer wraparound, all against the real depth. A queue model holds every accepted entry with its flags. The expected head status, error-anywhere flag and overrun state are derived from that model after each cycle.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  parameter int RXQ_DW = 8;

  typedef struct packed {
    logic              brk;
    logic              fe;
    logic              pe;
    logic [RXQ_DW-1:0] data;
  } rxq_entry_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  rxq_entry_t    wr_ent,
  input  logic          rhr_rd,
  output rxq_entry_t    top_ent,
  output logic          empty,
  output logic          push,
  output logic          pop,
  output logic          ovr,
  output logic [CW-1:0] fill
);
  rxq_entry_t    mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    empty    = (cnt_q == '0);
    full     = (cnt_q == CW'(DEPTH));
    pop      = rhr_rd && !empty;
    push     = wr_en && (!full || pop);
    ovr      = wr_en && full && !pop;
    wr_ptr_d = push ? nxt(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = pop ? nxt(rd_ptr_q) : rd_ptr_q;
    cnt_d    = cnt_q;
    if (push && !pop)      cnt_d = cnt_q + CW'(1);
    else if (pop && !push) cnt_d = cnt_q - CW'(1);
    top_ent  = mem[rd_ptr_q];
    fill     = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= wr_ent;
  end

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));
  assert_overrun_keeps_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fill == CW'(DEPTH) && !rhr_rd) |=> $stable(fill));
  assert_empty_read_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rhr_rd && fill == '0 && !wr_en) |=> (fill == '0));
endmodule

// File: rtl/rxq_errcnt.sv
module rxq_errcnt #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  input  logic [CW-1:0] fill,
  output logic          err_any
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    unique case ({inc, dec})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
    err_any = (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_errcnt_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= fill);
  assert_dec_has_error_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (cnt_q != '0));
endmodule

// File: rtl/rxq_ovr.sv
module rxq_ovr (
  input  logic clk,
  input  logic rst_n,
  input  logic ovr,
  input  logic lsr_rd,
  output logic oe
);
  logic oe_q, oe_d;

  always_comb begin
    oe_d = oe_q;
    if (lsr_rd) oe_d = 1'b0;
    if (ovr)    oe_d = 1'b1;
    oe = oe_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q <= 1'b0;
    else        oe_q <= oe_d;
  end

  assert_oe_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && !lsr_rd) |=> oe_q);
  assert_oe_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> oe_q);
endmodule

// File: rtl/rxq_errtrack.sv
module rxq_errtrack
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RXQ_DW-1:0] wr_data,
  input  logic              wr_brk,
  input  logic              wr_fe,
  input  logic              wr_pe,
  input  logic              rhr_rd,
  input  logic              lsr_rd,
  output logic [RXQ_DW-1:0] rd_data,
  output logic              lsr_err_any,
  output logic              lsr_brk,
  output logic              lsr_fe,
  output logic              lsr_pe,
  output logic              lsr_oe,
  output logic              data_rdy,
  output logic [CW-1:0]     fill_level
);
  rxq_entry_t wr_ent, top_ent;
  logic       empty, push, pop, ovr, inc, dec;

  always_comb begin
    wr_ent.brk  = wr_brk;
    wr_ent.fe   = wr_fe;
    wr_ent.pe   = wr_pe;
    wr_ent.data = wr_data;
  end

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ent(wr_ent), .rhr_rd(rhr_rd),
    .top_ent(top_ent), .empty(empty), .push(push), .pop(pop), .ovr(ovr),
    .fill(fill_level)
  );

  always_comb begin
    inc = push && (wr_brk || wr_fe || wr_pe);
    dec = pop && (top_ent.brk || top_ent.fe || top_ent.pe);
  end

  rxq_errcnt #(.DEPTH(DEPTH)) u_errcnt (
    .clk(clk), .rst_n(rst_n), .inc(inc), .dec(dec), .fill(fill_level),
    .err_any(lsr_err_any)
  );

  rxq_ovr u_ovr (
    .clk(clk), .rst_n(rst_n), .ovr(ovr), .lsr_rd(lsr_rd), .oe(lsr_oe)
  );

  always_comb begin
    data_rdy = !empty;
    rd_data  = empty ? '0 : top_ent.data;
    lsr_brk  = !empty && top_ent.brk;
    lsr_fe   = !empty && top_ent.fe;
    lsr_pe   = !empty && top_ent.pe;
  end

  assert_head_error_visible_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level != '0 && (lsr_brk || lsr_fe || lsr_pe)) |-> lsr_err_any);
  assert_ready_tracks_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    data_rdy == (fill_level != '0));
endmodule

// File: tb/rxq_errtrack_tb.sv
`timescale 1ns/1ps
module rxq_errtrack_tb;
  localparam int DEPTH = 64;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, wr_brk, wr_fe, wr_pe, rhr_rd, lsr_rd;
  logic [7:0] wr_data, rd_data;
  logic lsr_err_any, lsr_brk, lsr_fe, lsr_pe, lsr_oe, data_rdy;
  logic [CW-1:0] fill_level;

  always #2.5 clk = ~clk;

  rxq_errtrack #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_brk(wr_brk),
    .wr_fe(wr_fe), .wr_pe(wr_pe), .rhr_rd(rhr_rd), .lsr_rd(lsr_rd),
    .rd_data(rd_data), .lsr_err_any(lsr_err_any), .lsr_brk(lsr_brk),
    .lsr_fe(lsr_fe), .lsr_pe(lsr_pe), .lsr_oe(lsr_oe), .data_rdy(data_rdy),
    .fill_level(fill_level)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [10:0] sbq[$];   // {brk, fe, pe, data}
  bit model_oe = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit model_err();
    foreach (sbq[i]) if (sbq[i][10:8] != 3'b000) return 1;
    return 0;
  endfunction

  task automatic check_state();
    logic [10:0] h;
    h = (sbq.size() > 0) ? sbq[0] : 11'h0;
    chk(fill_level == CW'(sbq.size()), "R1 fill_level", fill_level, sbq.size());
    chk(data_rdy == (sbq.size() > 0), "R7 data_rdy", data_rdy, sbq.size() > 0);
    chk(rd_data == h[7:0], "R2 rd_data head", rd_data, h[7:0]);
    chk({lsr_brk, lsr_fe, lsr_pe} == h[10:8], "R3 head flags", {lsr_brk, lsr_fe, lsr_pe}, h[10:8]);
    chk(lsr_err_any == model_err(), "R4 err_any", lsr_err_any, model_err());
    chk(lsr_oe == model_oe, "R6 lsr_oe", lsr_oe, model_oe);
  endtask

  // Driver: one cycle of stimulus, scoreboard update, then state check.
  task automatic cyc(input bit we, input logic [10:0] e, input bit rd, input bit lr);
    bit popped, ov;
    wr_en = we; {wr_brk, wr_fe, wr_pe, wr_data} = e; rhr_rd = rd; lsr_rd = lr;
    // Monitor: a removal must deliver the scoreboard head.
    if (rd && sbq.size() > 0)
      chk({lsr_brk, lsr_fe, lsr_pe, rd_data} == sbq[0], "R2 popped entry",
          {lsr_brk, lsr_fe, lsr_pe, rd_data}, sbq[0]);
    @(negedge clk);
    popped = rd && sbq.size() > 0;
    if (popped) void'(sbq.pop_front());
    ov = 0;
    if (we) begin
      if (sbq.size() < DEPTH) sbq.push_back(e);
      else ov = 1;
    end
    if (lr) model_oe = 0;
    if (ov) model_oe = 1;
    wr_en = 0; rhr_rd = 0; lsr_rd = 0;
    check_state();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_data = 0; wr_brk = 0; wr_fe = 0; wr_pe = 0;
    rhr_rd = 0; lsr_rd = 0;
    repeat (3) @(negedge clk);
    check_state();            // reset state: R1 R3 R4 R6 R7
    rst_n = 1;
    @(negedge clk);

    // R1 R2 R3: clean bytes then one of each error kind
    cyc(1, {3'b000, 8'h11}, 0, 0);
    cyc(1, {3'b000, 8'h22}, 0, 0);
    cyc(1, {3'b100, 8'h33}, 0, 0);
    cyc(1, {3'b010, 8'h44}, 0, 0);
    cyc(1, {3'b001, 8'h55}, 0, 0);
    cyc(1, {3'b000, 8'h66}, 0, 0);
    // R4: err_any stays up until last erroneous byte leaves
    repeat (6) cyc(0, 11'h0, 1, 0);
    // R8: removal while empty ignored
    cyc(0, 11'h0, 1, 0);
    cyc(0, 11'h0, 1, 1);

    // R9: simultaneous write and removal, error in and error out
    cyc(1, {3'b010, 8'hA0}, 0, 0);
    cyc(1, {3'b001, 8'hA1}, 1, 0);
    cyc(1, {3'b000, 8'hA2}, 1, 0);
    cyc(0, 11'h0, 1, 0);

    // R1 R5: fill to the full boundary, errors scattered
    for (int i = 0; i < DEPTH; i++)
      cyc(1, {(i % 5 == 0) ? 3'b010 : 3'b000, 8'(i + 8'h40)}, 0, 0);
    cyc(1, {3'b100, 8'hEE}, 0, 0);   // R5 overrun, dropped
    cyc(1, {3'b000, 8'hEF}, 0, 1);   // R6 overrun with lsr_rd: stays set
    cyc(0, 11'h0, 0, 1);             // R6 cleared by lsr_rd alone
    cyc(1, {3'b001, 8'hF0}, 1, 0);   // R9 full: write with removal, no overrun
    cyc(1, {3'b000, 8'hF1}, 0, 0);   // R5 overrun again
    // R6: draining does not clear overrun; R2 R3 order preserved across wrap
    while (sbq.size() > 0) cyc(0, 11'h0, 1, 0);
    chk(lsr_oe == 1'b1, "R6 oe after drain", lsr_oe, 1);
    cyc(0, 11'h0, 0, 1);
    chk(lsr_oe == 1'b0, "R6 oe after lsr_rd", lsr_oe, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule